// File: doc/BRIEF.md
# Prioritised Interrupt Entry Controller

This block decides when a small 8-bit processor core leaves its instruction stream to enter an interrupt handler. There are two maskable sources. The first is a timer, whose events are latched into a pending bit until software writes the acknowledge strobe. The second is a video request, which is level-sensitive and stays asserted until its own source drops it. Requests are looked at only when the core signals that an instruction has finished. When both sources are pending, the timer always wins.

The interrupt-disable flag is kept here. Instructions that clear or set it report this alongside their completion strobe. The decision at a boundary uses the value the flag had when that instruction started. So clearing the flag opens the door only one instruction later, and a clear followed at once by a set still lets a waiting request in. Accepting an interrupt sets the flag again.

Entry is modelled as a fixed busy window of `ENTRY_CYCLES` cycles (8 by default). During that window further boundary strobes are ignored. A testbench can therefore measure the latency that the timer handler adds to a waiting video request. The FSM has two states. `ST_RUN` waits for boundaries, and its transition "accept" goes to `ST_ENTRY`. `ST_ENTRY` counts the entry cycles, and its transition "entry done" returns to `ST_RUN`.

Top module: `irq_entry_ctrl`

## Requirements
- R1: After reset `entry_start_o`, `busy_o`, `timer_pend_o` are 0, `vec_sel_o` is 2'b00 and `irq_off_o` is 1.
- R2: A video request present at a boundary whose instruction began with the flag clear is accepted: `entry_start_o` is 1 and `vec_sel_o` is 2'b10 in the cycle after that boundary edge, for exactly one cycle.
- R3: If the timer is pending and the video request is high at an accepting boundary, the timer is chosen (`vec_sel_o` = 2'b01).
- R4: No entry happens at a boundary whose instruction began with the flag set, including the boundary of the instruction that clears the flag; entry happens at the next boundary.
- R5: A flag clear followed immediately by a flag set in the next instruction admits a pending request at the boundary of the set instruction.
- R6: `busy_o` stays high for exactly `ENTRY_CYCLES` cycles after an acceptance, and boundary strobes during that window start nothing.
- R7: Acceptance sets the disable flag, so a request still present at the next boundary is not taken again.
- R8: A `timer_tick_i` pulse sets the timer pending bit; a `timer_ack_wr_i` pulse clears it one cycle later; a tick in the same cycle as an acknowledge wins; acceptance itself does not clear it.
- R9: A video request held during the timer handler is taken once the handler acknowledges the timer and clears the flag, one instruction after the clear.
- R10: A video request that rises and falls between two boundaries causes no entry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| insn_done_i | input | 1 | Instruction boundary strobe |
| flag_clr_i | input | 1 | Finishing instruction clears the disable flag |
| flag_set_i | input | 1 | Finishing instruction sets the disable flag |
| timer_tick_i | input | 1 | Timer event pulse |
| timer_ack_wr_i | input | 1 | Write strobe of the timer acknowledge register |
| video_req_i | input | 1 | Level video interrupt request |
| entry_start_o | output | 1 | One-cycle pulse at the start of interrupt entry |
| vec_sel_o | output | 2 | Chosen source during entry: 01 timer, 10 video, 00 none |
| busy_o | output | 1 | Entry sequence in progress |
| irq_off_o | output | 1 | Current interrupt-disable flag |
| timer_pend_o | output | 1 | Timer request pending |

## Verification
Acceptance is registered. `entry_start_o` and `vec_sel_o` therefore change in the cycle right after the boundary edge, and the bench samples them at the falling edge that follows the strobe. `busy_o` is counted over consecutive falling edges from that point and must total `ENTRY_CYCLES`. The effect of a flag instruction shows up only at the next boundary, so every masking check uses a pair of strobes and inspects the outputs after each one. The timer pending bit is checked one falling edge after a tick or acknowledge pulse.

// File: rtl/irqe_pkg.sv
package irqe_pkg;

    // Source indices; a lower index has higher priority.
    localparam int SRC_TIMER = 0;
    localparam int SRC_VIDEO = 1;
    localparam int NUM_SRC   = 2;

    typedef enum logic {
        ST_RUN   = 1'b0,
        ST_ENTRY = 1'b1
    } irqe_state_e;

endpackage

// File: rtl/irqe_tmr_latch.sv
module irqe_tmr_latch (
    input  logic clk,
    input  logic rst_n,
    input  logic tick_i,
    input  logic ack_i,
    output logic pend_o
);

    logic pend_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend_q <= 1'b0;
        end else if (tick_i) begin
            pend_q <= 1'b1;
        end else if (ack_i) begin
            pend_q <= 1'b0;
        end
    end

    assign pend_o = pend_q;

    AST_ACK_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_i && !tick_i) |=> !pend_o); // R8

    AST_TICK_SETS: assert property (@(posedge clk) disable iff (!rst_n)
        tick_i |=> pend_o); // R8

endmodule

// File: rtl/irqe_mask_reg.sv
module irqe_mask_reg (
    input  logic clk,
    input  logic rst_n,
    input  logic boundary_i,
    input  logic clr_i,
    input  logic set_i,
    input  logic take_i,
    output logic dis_o
);

    logic dis_q;

    // The value held here is the flag as the current instruction saw it
    // at its start; the instruction's own effect lands at its boundary.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dis_q <= 1'b1;
        end else if (boundary_i) begin
            if (take_i || set_i) begin
                dis_q <= 1'b1;
            end else if (clr_i) begin
                dis_q <= 1'b0;
            end
        end
    end

    assign dis_o = dis_q;

    AST_TAKE_MASKS: assert property (@(posedge clk) disable iff (!rst_n)
        (boundary_i && take_i) |=> dis_o); // R7

    AST_CLR_OPENS: assert property (@(posedge clk) disable iff (!rst_n)
        (boundary_i && clr_i && !set_i && !take_i) |=> !dis_o); // R4

endmodule

// File: rtl/irqe_arbiter.sv
module irqe_arbiter #(
    parameter int NUM_SRC = 2
) (
    input  logic [NUM_SRC-1:0] req_i,
    output logic [NUM_SRC-1:0] grant_o,
    output logic               any_o
);

    logic [NUM_SRC:0] seen;

    assign seen[0] = 1'b0;

    generate
        for (genvar i = 0; i < NUM_SRC; i++) begin : g_prio
            assign seen[i+1]  = seen[i] | req_i[i];
            assign grant_o[i] = req_i[i] & ~seen[i];
        end
    endgenerate

    assign any_o = seen[NUM_SRC];

    always_comb begin
        AST_GRANT_ONEHOT: assert ($onehot0(grant_o)); // R3
    end

endmodule

// File: rtl/irqe_entry_fsm.sv
module irqe_entry_fsm
    import irqe_pkg::*;
#(
    parameter int NUM_SRC      = 2,
    parameter int ENTRY_CYCLES = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               take_i,
    input  logic [NUM_SRC-1:0] grant_i,
    output logic               busy_o,
    output logic               start_o,
    output logic [NUM_SRC-1:0] vec_o
);

    localparam int CNT_W = $clog2(ENTRY_CYCLES + 1);
    localparam logic [CNT_W-1:0] CNT_LOAD = CNT_W'(ENTRY_CYCLES - 1);

    irqe_state_e      state_q, state_d;
    logic [CNT_W-1:0] cnt_q, cnt_d;
    logic [NUM_SRC-1:0] vec_q, vec_d;
    logic             start_q, start_d;

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_RUN;
            cnt_q   <= '0;
            vec_q   <= '0;
            start_q <= 1'b0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
            vec_q   <= vec_d;
            start_q <= start_d;
        end
    end

    // Next state and outputs
    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        vec_d   = vec_q;
        start_d = 1'b0;
        unique case (state_q)
            ST_RUN: begin
                if (take_i) begin          // accept
                    state_d = ST_ENTRY;
                    cnt_d   = CNT_LOAD;
                    vec_d   = grant_i;
                    start_d = 1'b1;
                end
            end
            ST_ENTRY: begin
                if (cnt_q == '0) begin     // entry done
                    state_d = ST_RUN;
                    vec_d   = '0;
                end else begin
                    cnt_d = cnt_q - 1'b1;
                end
            end
            default: state_d = ST_RUN;
        endcase
    end

    assign busy_o  = (state_q == ST_ENTRY);
    assign start_o = start_q;
    assign vec_o   = vec_q;

    // Checker counter for the busy window length.
    logic [CNT_W:0] run_q;
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            run_q <= '0;
        end else if (busy_o) begin
            run_q <= run_q + 1'b1;
        end else begin
            run_q <= '0;
        end
    end

    AST_BUSY_LEN: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy_o) |-> (run_q == (CNT_W+1)'(ENTRY_CYCLES))); // R6

    AST_BUSY_MAX: assert property (@(posedge clk) disable iff (!rst_n)
        (run_q == (CNT_W+1)'(ENTRY_CYCLES)) |-> !busy_o); // R6

    AST_START_FROM_TAKE: assert property (@(posedge clk) disable iff (!rst_n)
        start_o |-> (busy_o && $past(take_i))); // R2

endmodule

// File: rtl/irq_entry_ctrl.sv
module irq_entry_ctrl
    import irqe_pkg::*;
#(
    parameter int ENTRY_CYCLES = 8
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       insn_done_i,
    input  logic       flag_clr_i,
    input  logic       flag_set_i,
    input  logic       timer_tick_i,
    input  logic       timer_ack_wr_i,
    input  logic       video_req_i,
    output logic       entry_start_o,
    output logic [1:0] vec_sel_o,
    output logic       busy_o,
    output logic       irq_off_o,
    output logic       timer_pend_o
);

    logic               tmr_pend;
    logic               dis;
    logic               busy;
    logic               boundary;
    logic               take;
    logic               any_req;
    logic [NUM_SRC-1:0] req;
    logic [NUM_SRC-1:0] grant;
    logic [NUM_SRC-1:0] vec;
    logic               start;

    irqe_tmr_latch u_tmr (
        .clk    (clk),
        .rst_n  (rst_n),
        .tick_i (timer_tick_i),
        .ack_i  (timer_ack_wr_i),
        .pend_o (tmr_pend)
    );

    assign req[SRC_TIMER] = tmr_pend;
    assign req[SRC_VIDEO] = video_req_i;

    irqe_arbiter #(.NUM_SRC(NUM_SRC)) u_arb (
        .req_i   (req),
        .grant_o (grant),
        .any_o   (any_req)
    );

    // Boundaries count only outside the entry window.
    assign boundary = insn_done_i & ~busy;
    assign take     = boundary & ~dis & any_req;

    irqe_mask_reg u_mask (
        .clk        (clk),
        .rst_n      (rst_n),
        .boundary_i (boundary),
        .clr_i      (flag_clr_i),
        .set_i      (flag_set_i),
        .take_i     (take),
        .dis_o      (dis)
    );

    irqe_entry_fsm #(
        .NUM_SRC      (NUM_SRC),
        .ENTRY_CYCLES (ENTRY_CYCLES)
    ) u_fsm (
        .clk     (clk),
        .rst_n   (rst_n),
        .take_i  (take),
        .grant_i (grant),
        .busy_o  (busy),
        .start_o (start),
        .vec_o   (vec)
    );

    assign entry_start_o = start;
    assign vec_sel_o     = vec;
    assign busy_o        = busy;
    assign irq_off_o     = dis;
    assign timer_pend_o  = tmr_pend;

    AST_TIMER_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
        (insn_done_i && !busy_o && !irq_off_o && timer_pend_o)
        |=> (entry_start_o && vec_sel_o == 2'b01)); // R3

    AST_MASK_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
        (insn_done_i && irq_off_o) |=> !entry_start_o); // R4

    AST_AUTO_MASK: assert property (@(posedge clk) disable iff (!rst_n)
        entry_start_o |-> irq_off_o); // R7

    AST_NO_START_OFF_BOUNDARY: assert property (@(posedge clk) disable iff (!rst_n)
        !(insn_done_i && !busy_o) |=> !entry_start_o); // R10

endmodule

// File: tb/irq_entry_ctrl_test.sv
`timescale 1ns/1ps
module irq_entry_ctrl_test;

    localparam int ENTRY_CYCLES = 8;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       insn_done_i = 1'b0;
    logic       flag_clr_i = 1'b0;
    logic       flag_set_i = 1'b0;
    logic       timer_tick_i = 1'b0;
    logic       timer_ack_wr_i = 1'b0;
    logic       video_req_i = 1'b0;
    logic       entry_start_o;
    logic [1:0] vec_sel_o;
    logic       busy_o;
    logic       irq_off_o;
    logic       timer_pend_o;

    int total = 0;
    int bad = 0;
    int cyc = 0;

    always #2.5 clk = ~clk;

    irq_entry_ctrl #(.ENTRY_CYCLES(ENTRY_CYCLES)) uut (
        .clk            (clk),
        .rst_n          (rst_n),
        .insn_done_i    (insn_done_i),
        .flag_clr_i     (flag_clr_i),
        .flag_set_i     (flag_set_i),
        .timer_tick_i   (timer_tick_i),
        .timer_ack_wr_i (timer_ack_wr_i),
        .video_req_i    (video_req_i),
        .entry_start_o  (entry_start_o),
        .vec_sel_o      (vec_sel_o),
        .busy_o         (busy_o),
        .irq_off_o      (irq_off_o),
        .timer_pend_o   (timer_pend_o)
    );

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > 20000) begin
            bad = bad + 1;
            total = total + 1;
            $display("FAIL watchdog: act=hung exp=finished");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    task automatic check(input logic ok, input string tag, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s: act=%0d exp=%0d", tag, act, exp);
        end
    endtask

    task automatic check_eq(input string tag, input int act, input int exp);
        check(act == exp, tag, act, exp);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        insn_done_i = 0; flag_clr_i = 0; flag_set_i = 0;
        timer_tick_i = 0; timer_ack_wr_i = 0; video_req_i = 0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
    endtask

    // One instruction boundary; outputs are sampled after it returns.
    task automatic run_insn(input logic clr, input logic set);
        @(negedge clk);
        insn_done_i = 1'b1; flag_clr_i = clr; flag_set_i = set;
        @(negedge clk);
        insn_done_i = 1'b0; flag_clr_i = 1'b0; flag_set_i = 1'b0;
    endtask

    task automatic pulse_tick();
        @(negedge clk); timer_tick_i = 1'b1;
        @(negedge clk); timer_tick_i = 1'b0;
    endtask

    task automatic pulse_ack();
        @(negedge clk); timer_ack_wr_i = 1'b1;
        @(negedge clk); timer_ack_wr_i = 1'b0;
    endtask

    task automatic wait_idle();
        for (int k = 0; k < 40; k++) begin
            if (!busy_o) break;
            @(negedge clk);
        end
    endtask

    task automatic t_reset();
        do_reset();
        @(negedge clk);
        check_eq("R1 entry_start", entry_start_o, 0);
        check_eq("R1 busy", busy_o, 0);
        check_eq("R1 vec", vec_sel_o, 0);
        check_eq("R1 irq_off", irq_off_o, 1);
        check_eq("R1 timer_pend", timer_pend_o, 0);
    endtask

    task automatic t_video_entry();
        int n;
        int extra;
        do_reset();
        video_req_i = 1'b1;
        run_insn(1'b1, 1'b0);
        check_eq("R4 no entry at clearing boundary", entry_start_o, 0);
        run_insn(1'b0, 1'b0);
        check_eq("R2 entry start", entry_start_o, 1);
        check_eq("R2 vec video", vec_sel_o, 2);
        check_eq("R7 flag set on entry", irq_off_o, 1);
        n = 1; extra = 0;
        insn_done_i = 1'b1;
        for (int k = 0; k < 20; k++) begin
            @(negedge clk);
            if (entry_start_o) extra++;
            if (!busy_o) break;
            n++;
        end
        insn_done_i = 1'b0;
        check_eq("R6 busy length", n, ENTRY_CYCLES);
        check_eq("R6 no restart during busy", extra, 0);
        check_eq("R2 vec cleared after entry", vec_sel_o, 0);
        run_insn(1'b0, 1'b0);
        check_eq("R7 no re-entry while masked", entry_start_o, 0);
        video_req_i = 1'b0;
    endtask

    task automatic t_priority();
        do_reset();
        pulse_tick();
        check_eq("R8 tick sets pending", timer_pend_o, 1);
        video_req_i = 1'b1;
        run_insn(1'b1, 1'b0);
        check_eq("R4 masked boundary", entry_start_o, 0);
        run_insn(1'b0, 1'b0);
        check_eq("R3 entry start", entry_start_o, 1);
        check_eq("R3 timer wins", vec_sel_o, 1);
        wait_idle();
        check_eq("R8 entry keeps pending", timer_pend_o, 1);
        pulse_ack();
        check_eq("R8 ack clears pending", timer_pend_o, 0);
        run_insn(1'b1, 1'b0);
        check_eq("R9 not at handler clear", entry_start_o, 0);
        run_insn(1'b0, 1'b0);
        check_eq("R9 video taken after handler", entry_start_o, 1);
        check_eq("R9 vec video", vec_sel_o, 2);
        wait_idle();
        video_req_i = 1'b0;
    endtask

    task automatic t_clr_set_pair();
        do_reset();
        pulse_tick();
        run_insn(1'b1, 1'b0);
        check_eq("R5 nothing at clear", entry_start_o, 0);
        run_insn(1'b0, 1'b1);
        check_eq("R5 entry at set boundary", entry_start_o, 1);
        check_eq("R5 vec timer", vec_sel_o, 1);
        wait_idle();
    endtask

    task automatic t_between_boundaries();
        do_reset();
        run_insn(1'b1, 1'b0);
        run_insn(1'b0, 1'b0);
        check_eq("R10 flag open", irq_off_o, 0);
        @(negedge clk); video_req_i = 1'b1;
        @(negedge clk);
        @(negedge clk); video_req_i = 1'b0;
        @(negedge clk);
        check_eq("R10 no entry between boundaries", entry_start_o | busy_o, 0);
        run_insn(1'b0, 1'b0);
        check_eq("R10 no entry at later boundary", entry_start_o, 0);
    endtask

    task automatic t_tick_ack_race();
        do_reset();
        @(negedge clk); timer_tick_i = 1'b1; timer_ack_wr_i = 1'b1;
        @(negedge clk); timer_tick_i = 1'b0; timer_ack_wr_i = 1'b0;
        check_eq("R8 tick beats ack", timer_pend_o, 1);
        pulse_ack();
        check_eq("R8 ack alone clears", timer_pend_o, 0);
    endtask

    initial begin
        t_reset();
        t_video_entry();
        t_priority();
        t_clr_set_pair();
        t_between_boundaries();
        t_tick_ack_race();
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule